// File: doc/BRIEF.md
# Extended Stack Pointer Unit

This block keeps the stack pointer of an 8-bit processor core and widens its reach from 256 bytes to 1K. An 8-bit low pointer moves on every push and pop. A 2-bit extension register supplies the two upper address bits. When extended stacking is in force, the low pointer wrapping past its top or bottom carries into the extension or borrows from it. The unit sends a 10-bit address to the stack memory. It also lets software read and write both registers directly.

A push increments the low pointer before the write, so the address output then points at the new top entry. A pop decrements it after the read. Extended stacking is on only when the auto-extend enable is high and the memory-configuration field is not 2'b11. The value 2'b11 hands the on-chip RAM to program and data use, and in that case extension is off whatever the enable says. When extension is off, the extension register stays readable and writable but has no effect on the address or on wrapping.

Top module: `xsp_unit`

## Requirements
- R1: After a synchronous reset the low pointer reads 8'h07, the extension register reads 8'hFC (its two writable bits are zero), and the stack address is 10'h007.
- R2: A push alone raises the low pointer by one and a pop alone lowers it by one (modulo 256). A push and a pop in the same cycle leave both registers unchanged.
- R3: With extension active, a push while the low pointer is 8'hFF gives 8'h00 and raises the extension bits by one modulo 4 (3 becomes 0).
- R4: With extension active, a pop while the low pointer is 8'h00 gives 8'hFF and lowers the extension bits by one modulo 4 (0 becomes 3).
- R5: With the auto-extend enable low, wraps of the low pointer leave the extension bits unchanged, the stack address is {2'b00, low pointer}, and the extension bits can still be written and read back.
- R6: When the memory-configuration field is 2'b11, extension is inactive even with the enable high: wraps leave the extension bits alone and the address upper bits are zero. The ext_active output is 1 only when the enable is 1 and the field is not 2'b11.
- R7: Extension read bits 7:2 always read 1 and ignore writes. Bits 1:0 take bits 1:0 of the written byte.
- R8: A direct write loads the low pointer with the written byte in the next cycle, never carries into or borrows from the extension bits, and takes precedence over a push or pop in the same cycle.
- R9: A direct write to the extension register takes precedence over a carry or borrow in the same cycle.
- R10: With extension active, the stack address is {extension bits, low pointer}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_req | input | 1 | Push request (pre-increment) |
| pop_req | input | 1 | Pop request (post-decrement) |
| sp_wr_en | input | 1 | Direct write strobe for the low pointer |
| sp_wr_data | input | 8 | Data for a low-pointer write |
| ext_wr_en | input | 1 | Direct write strobe for the extension register |
| ext_wr_data | input | 8 | Data for an extension write (bits 1:0 used) |
| sa_en | input | 1 | Auto-extend enable |
| mem_cfg | input | 2 | Memory configuration; 2'b11 disables extension |
| sp_rd | output | 8 | Current low pointer |
| ext_rd | output | 8 | Extension register read value |
| stack_addr | output | 10 | Address presented to the stack memory |
| ext_active | output | 1 | Extended stacking currently in force |

## Verification
The checker assumes that every input is a known, synchronous value sampled at the rising edge. It also assumes that the mode inputs hold steady during the cycle they govern, since a carry is judged on the enable and configuration sampled in that same cycle. The bench changes all inputs a short time after a rising edge, so each stimulus cycle has one settled set of inputs. Mode changes are made in cycles with no push or pop, so no wrap coincides with a mode switch unless a test intends it.

// File: rtl/xsp_pkg.sv
package xsp_pkg;

    localparam int unsigned XSP_SP_W    = 8;
    localparam int unsigned XSP_EXT_W   = 2;
    localparam int unsigned XSP_REG_W   = 8;
    localparam logic [1:0]  XSP_CFG_OFF = 2'b11;

    typedef enum logic [1:0] {
        SP_HOLD = 2'd0,
        SP_LOAD = 2'd1,
        SP_PUSH = 2'd2,
        SP_POP  = 2'd3
    } sp_op_e;

    typedef struct packed {
        logic carry;
        logic borrow;
    } wrap_t;

    // Direct write wins; simultaneous push and pop cancel out.
    function automatic sp_op_e decode_op(input logic push, input logic pop,
                                         input logic wr);
        if (wr)               return SP_LOAD;
        else if (push && !pop) return SP_PUSH;
        else if (pop && !push) return SP_POP;
        else                  return SP_HOLD;
    endfunction

    function automatic logic ext_mode_on(input logic sa, input logic [1:0] cfg);
        return sa && (cfg != XSP_CFG_OFF);
    endfunction

endpackage

// File: rtl/xsp_mode.sv
module xsp_mode (
    input  logic       sa_en,
    input  logic [1:0] mem_cfg,
    output logic       active
);
    import xsp_pkg::*;

    always_comb begin
        active = ext_mode_on(sa_en, mem_cfg);
    end
endmodule

// File: rtl/xsp_low.sv
module xsp_low #(
    parameter int unsigned SP_W     = 8,
    parameter logic [SP_W-1:0] SP_RST = 8'h07
) (
    input  logic                clk,
    input  logic                rst,
    input  xsp_pkg::sp_op_e     op,
    input  logic [SP_W-1:0]     wr_data,
    output logic [SP_W-1:0]     sp_q,
    output xsp_pkg::wrap_t      wrap
);
    import xsp_pkg::*;

    localparam logic [SP_W-1:0] SP_TOP = {SP_W{1'b1}};
    localparam logic [SP_W-1:0] SP_ONE = {{(SP_W-1){1'b0}}, 1'b1};

    logic [SP_W-1:0] sp_d;

    always_comb begin
        wrap.carry  = (op == SP_PUSH) && (sp_q == SP_TOP);
        wrap.borrow = (op == SP_POP)  && (sp_q == '0);
        unique case (op)
            SP_LOAD: sp_d = wr_data;
            SP_PUSH: sp_d = sp_q + SP_ONE;
            SP_POP:  sp_d = sp_q - SP_ONE;
            default: sp_d = sp_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) sp_q <= SP_RST;
        else     sp_q <= sp_d;
    end
endmodule

// File: rtl/xsp_high.sv
module xsp_high #(
    parameter int unsigned EXT_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              active,
    input  xsp_pkg::wrap_t    wrap,
    input  logic              wr_en,
    input  logic [EXT_W-1:0]  wr_data,
    output logic [EXT_W-1:0]  ext_q
);
    localparam logic [EXT_W-1:0] EXT_ONE = {{(EXT_W-1){1'b0}}, 1'b1};

    logic [EXT_W-1:0] ext_d;

    always_comb begin
        if (wr_en)                     ext_d = wr_data;
        else if (active && wrap.carry)  ext_d = ext_q + EXT_ONE;
        else if (active && wrap.borrow) ext_d = ext_q - EXT_ONE;
        else                           ext_d = ext_q;
    end

    always_ff @(posedge clk) begin
        if (rst) ext_q <= '0;
        else     ext_q <= ext_d;
    end
endmodule

// File: rtl/xsp_unit.sv
module xsp_unit #(
    parameter int unsigned SP_W   = xsp_pkg::XSP_SP_W,
    parameter int unsigned EXT_W  = xsp_pkg::XSP_EXT_W,
    parameter int unsigned REG_W  = xsp_pkg::XSP_REG_W,
    parameter int unsigned ADDR_W = SP_W + EXT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push_req,
    input  logic              pop_req,
    input  logic              sp_wr_en,
    input  logic [SP_W-1:0]   sp_wr_data,
    input  logic              ext_wr_en,
    input  logic [REG_W-1:0]  ext_wr_data,
    input  logic              sa_en,
    input  logic [1:0]        mem_cfg,
    output logic [SP_W-1:0]   sp_rd,
    output logic [REG_W-1:0]  ext_rd,
    output logic [ADDR_W-1:0] stack_addr,
    output logic              ext_active
);
    import xsp_pkg::*;

    localparam int unsigned PAD_W = REG_W - EXT_W;

    sp_op_e           op;
    wrap_t            wrap;
    logic [EXT_W-1:0] ext_q;
    logic             active;

    always_comb op = decode_op(push_req, pop_req, sp_wr_en);

    xsp_mode u_mode (
        .sa_en   (sa_en),
        .mem_cfg (mem_cfg),
        .active  (active)
    );

    xsp_low #(.SP_W(SP_W)) u_low (
        .clk     (clk),
        .rst     (rst),
        .op      (op),
        .wr_data (sp_wr_data),
        .sp_q    (sp_rd),
        .wrap    (wrap)
    );

    xsp_high #(.EXT_W(EXT_W)) u_high (
        .clk     (clk),
        .rst     (rst),
        .active  (active),
        .wrap    (wrap),
        .wr_en   (ext_wr_en),
        .wr_data (ext_wr_data[EXT_W-1:0]),
        .ext_q   (ext_q)
    );

    always_comb begin
        ext_rd     = {{PAD_W{1'b1}}, ext_q};
        ext_active = active;
        stack_addr = active ? {ext_q, sp_rd} : {{EXT_W{1'b0}}, sp_rd};
    end
endmodule

// File: rtl/xsp_unit_chk.sv
module xsp_unit_chk #(
    parameter int unsigned SP_W   = 8,
    parameter int unsigned EXT_W  = 2,
    parameter int unsigned REG_W  = 8,
    parameter int unsigned ADDR_W = SP_W + EXT_W
) (
    input logic              clk,
    input logic              rst,
    input logic              push_req,
    input logic              pop_req,
    input logic              sp_wr_en,
    input logic [SP_W-1:0]   sp_wr_data,
    input logic              ext_wr_en,
    input logic [REG_W-1:0]  ext_wr_data,
    input logic              sa_en,
    input logic [1:0]        mem_cfg,
    input logic [SP_W-1:0]   sp_rd,
    input logic [REG_W-1:0]  ext_rd,
    input logic [ADDR_W-1:0] stack_addr,
    input logic              ext_active
);
    localparam int unsigned PAD_W = REG_W - EXT_W;
    localparam logic [SP_W-1:0]  SP_ONE  = {{(SP_W-1){1'b0}}, 1'b1};
    localparam logic [EXT_W-1:0] EXT_ONE = {{(EXT_W-1){1'b0}}, 1'b1};

    logic mode_in;
    always_comb mode_in = sa_en && (mem_cfg != 2'b11);

    assert_push_step_R2: assert property (@(posedge clk) disable iff (rst)
        (push_req && !pop_req && !sp_wr_en) |=> (sp_rd == $past(sp_rd) + SP_ONE));

    assert_both_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (push_req && pop_req && !sp_wr_en) |=> $stable(sp_rd));

    assert_carry_up_R3: assert property (@(posedge clk) disable iff (rst)
        (mode_in && push_req && !pop_req && !sp_wr_en && !ext_wr_en &&
         sp_rd == {SP_W{1'b1}})
        |=> (ext_rd[EXT_W-1:0] == $past(ext_rd[EXT_W-1:0]) + EXT_ONE));

    assert_borrow_down_R4: assert property (@(posedge clk) disable iff (rst)
        (mode_in && pop_req && !push_req && !sp_wr_en && !ext_wr_en &&
         sp_rd == '0)
        |=> (ext_rd[EXT_W-1:0] == $past(ext_rd[EXT_W-1:0]) - EXT_ONE));

    assert_ext_frozen_R5: assert property (@(posedge clk) disable iff (rst)
        (!mode_in && !ext_wr_en) |=> $stable(ext_rd));

    assert_addr_plain_R6: assert property (@(posedge clk) disable iff (rst)
        !ext_active |-> (stack_addr[ADDR_W-1:SP_W] == '0));

    assert_active_flag_R6: assert property (@(posedge clk) disable iff (rst)
        ext_active == mode_in);

    assert_pad_ones_R7: assert property (@(posedge clk) disable iff (rst)
        ext_rd[REG_W-1:EXT_W] == {PAD_W{1'b1}});

    assert_load_sp_R8: assert property (@(posedge clk) disable iff (rst)
        sp_wr_en |=> (sp_rd == $past(sp_wr_data)));

    assert_ext_load_R9: assert property (@(posedge clk) disable iff (rst)
        ext_wr_en |=> (ext_rd[EXT_W-1:0] == $past(ext_wr_data[EXT_W-1:0])));

    assert_addr_low_R10: assert property (@(posedge clk) disable iff (rst)
        stack_addr[SP_W-1:0] == sp_rd);
endmodule

bind xsp_unit xsp_unit_chk #(
    .SP_W(SP_W), .EXT_W(EXT_W), .REG_W(REG_W), .ADDR_W(ADDR_W)
) u_chk (
    .clk(clk), .rst(rst), .push_req(push_req), .pop_req(pop_req),
    .sp_wr_en(sp_wr_en), .sp_wr_data(sp_wr_data), .ext_wr_en(ext_wr_en),
    .ext_wr_data(ext_wr_data), .sa_en(sa_en), .mem_cfg(mem_cfg),
    .sp_rd(sp_rd), .ext_rd(ext_rd), .stack_addr(stack_addr),
    .ext_active(ext_active)
);

// File: tb/tb_xsp_unit.sv
module tb_xsp_unit;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       push_req = 0, pop_req = 0, sp_wr_en = 0, ext_wr_en = 0;
    logic [7:0] sp_wr_data = '0, ext_wr_data = '0;
    logic       sa_en = 0;
    logic [1:0] mem_cfg = 2'b00;
    logic [7:0] sp_rd, ext_rd;
    logic [9:0] stack_addr;
    logic       ext_active;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    xsp_unit dut (
        .clk(clk), .rst(rst), .push_req(push_req), .pop_req(pop_req),
        .sp_wr_en(sp_wr_en), .sp_wr_data(sp_wr_data), .ext_wr_en(ext_wr_en),
        .ext_wr_data(ext_wr_data), .sa_en(sa_en), .mem_cfg(mem_cfg),
        .sp_rd(sp_rd), .ext_rd(ext_rd), .stack_addr(stack_addr),
        .ext_active(ext_active)
    );

    task automatic check(input string req, input logic [15:0] act,
                         input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One clock: inputs were set after the previous edge; sample 2 ns past this edge.
    task automatic tick();
        @(posedge clk);
        #2;
        push_req = 0; pop_req = 0; sp_wr_en = 0; ext_wr_en = 0;
    endtask

    task automatic set_sp(input logic [7:0] v);
        sp_wr_en = 1; sp_wr_data = v; tick();
    endtask

    task automatic set_ext(input logic [7:0] v);
        ext_wr_en = 1; ext_wr_data = v; tick();
    endtask

    task automatic t_reset();
        check("R1 sp", {8'h0, sp_rd}, 16'h0007);
        check("R1 ext", {8'h0, ext_rd}, 16'h00FC);
        check("R1 addr", {6'h0, stack_addr}, 16'h0007);
    endtask

    task automatic t_push_pop();
        sa_en = 1; mem_cfg = 2'b00;
        set_sp(8'h40);
        push_req = 1; tick();
        check("R2 push", {8'h0, sp_rd}, 16'h0041);
        pop_req = 1; tick();
        pop_req = 1; tick();
        check("R2 pop", {8'h0, sp_rd}, 16'h003F);
        push_req = 1; pop_req = 1; tick();
        check("R2 both", {8'h0, sp_rd}, 16'h003F);
        check("R2 both ext", {8'h0, ext_rd}, 16'h00FC);
    endtask

    task automatic t_wrap_up();
        sa_en = 1; mem_cfg = 2'b01;
        set_ext(8'h01);
        set_sp(8'hFF);
        push_req = 1; tick();
        check("R3 sp", {8'h0, sp_rd}, 16'h0000);
        check("R3 ext", {8'h0, ext_rd}, 16'h00FE);
        check("R10 addr", {6'h0, stack_addr}, 16'h0200);
        set_ext(8'h03);
        set_sp(8'hFF);
        push_req = 1; tick();
        check("R3 ext wrap", {8'h0, ext_rd}, 16'h00FC);
    endtask

    task automatic t_wrap_down();
        sa_en = 1; mem_cfg = 2'b10;
        set_ext(8'h02);
        set_sp(8'h00);
        pop_req = 1; tick();
        check("R4 sp", {8'h0, sp_rd}, 16'h00FF);
        check("R4 ext", {8'h0, ext_rd}, 16'h00FD);
        check("R10 addr", {6'h0, stack_addr}, 16'h01FF);
        set_ext(8'h00);
        set_sp(8'h00);
        pop_req = 1; tick();
        check("R4 ext wrap", {8'h0, ext_rd}, 16'h00FF);
    endtask

    task automatic t_sa_off();
        sa_en = 0; mem_cfg = 2'b00;
        set_ext(8'h02);
        check("R5 rw", {8'h0, ext_rd}, 16'h00FE);
        check("R5 addr", {6'h0, stack_addr}, 16'h00FF);
        set_sp(8'hFF);
        push_req = 1; tick();
        check("R5 carry", {8'h0, ext_rd}, 16'h00FE);
        pop_req = 1; tick();
        check("R5 borrow", {8'h0, ext_rd}, 16'h00FE);
        check("R5 sp", {8'h0, sp_rd}, 16'h00FF);
    endtask

    task automatic t_cfg_off();
        sa_en = 1; mem_cfg = 2'b11;
        set_ext(8'h01);
        #1 check("R6 flag", {15'h0, ext_active}, 16'h0000);
        set_sp(8'hFF);
        push_req = 1; tick();
        check("R6 carry", {8'h0, ext_rd}, 16'h00FD);
        check("R6 addr", {6'h0, stack_addr}, 16'h0000);
        mem_cfg = 2'b00; #1;
        check("R6 flag on", {15'h0, ext_active}, 16'h0001);
        check("R10 addr", {6'h0, stack_addr}, 16'h0100);
    endtask

    task automatic t_reserved();
        set_ext(8'h00);
        check("R7 zero", {8'h0, ext_rd}, 16'h00FC);
        set_ext(8'h5E);
        check("R7 mixed", {8'h0, ext_rd}, 16'h00FE);
    endtask

    task automatic t_sp_write();
        sa_en = 1; mem_cfg = 2'b00;
        set_ext(8'h01);
        set_sp(8'hFF);
        sp_wr_en = 1; sp_wr_data = 8'h00; push_req = 1; tick();
        check("R8 load", {8'h0, sp_rd}, 16'h0000);
        check("R8 nocarry", {8'h0, ext_rd}, 16'h00FD);
        sp_wr_en = 1; sp_wr_data = 8'h33; pop_req = 1; tick();
        check("R8 nob", {8'h0, sp_rd}, 16'h0033);
        check("R8 ext", {8'h0, ext_rd}, 16'h00FD);
    endtask

    task automatic t_ext_prio();
        sa_en = 1; mem_cfg = 2'b00;
        set_ext(8'h01);
        set_sp(8'hFF);
        push_req = 1; ext_wr_en = 1; ext_wr_data = 8'h03; tick();
        check("R9 carry", {8'h0, ext_rd}, 16'h00FF);
        check("R9 sp", {8'h0, sp_rd}, 16'h0000);
        pop_req = 1; ext_wr_en = 1; ext_wr_data = 8'h00; tick();
        check("R9 borrow", {8'h0, ext_rd}, 16'h00FC);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2 rst = 0;
        #1;
        t_reset();
        t_push_pop();
        t_wrap_up();
        t_wrap_down();
        t_sa_off();
        t_cfg_off();
        t_reserved();
        t_sp_write();
        t_ext_prio();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #200000;
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule